// File: doc/BRIEF.md
# Daisy-Chain Converter Serial Port with Completion Flag

This block is the digital serial port of one converter in a daisy chain. Every device in the chain shares the conversion-start line `cnv` and the serial clock `sck`. Each device's `sdi` comes from the `sdo` of the device further from the host. The first device has `sdi` tied high. The conversion itself is a stub: it latches `sample_in` when a conversion starts and presents that value as the result `CONV_CYCLES` clock cycles later.

A conversion starts when `cnv` rises while `sck` is high. `cnv` then stays high through conversion and readback. Once a device has finished converting, its `sdo` follows its `sdi`. The high level from the first device therefore reaches the host only after every device has finished, so the host's `sdo` line works as a chain-wide done flag.

The first `sck` falling edge after that puts the MSB of each device's result on its `sdo`. Every later falling edge shifts each register left by one and takes `sdi` into the LSB. As a result, N devices read back as one register of 16·N bits, and readback takes 16·N+1 falling edges. The inputs `cnv`, `sck` and `sdi` are sampled by the block clock `clk`, and edges are detected from those samples.

Top module: `chain_adc_port`

## Requirements
- R1: While `cnv` is low, `sdo` is low. This holds whatever the levels on `sdi` and `sck` are. It also covers the case where `cnv` and `sdi` are both low.
- R2: A conversion starts only on a rising `cnv` sampled while `sck` is high. A `cnv` rise seen while `sck` is low is ignored, and raising `sck` afterwards does not start one.
- R3: A conversion started on clock edge E0 completes on edge E0+`CONV_CYCLES`. `sdo` is low from the start edge until completion.
- R4: After completion and before the first `sck` falling edge, `sdo` equals `sdi`. `sdo` is therefore high only when this device is done and its `sdi` is high.
- R5: The first `sck` falling edge after completion presents bit W-1 of the latched sample on `sdo` without shifting. Each later falling edge shifts left by one, so the bits appear in the order W-1 down to 0.
- R6: `sck` falling edges during a conversion leave the latched sample unchanged, and so do edges while idle. The value later read out is the one that `sample_in` had at the start edge.
- R7: Each shift after the first falling edge captures `sdi` into bit 0. In a chain of N devices, falling edge k (1 ≤ k ≤ 16·N) shows bit 15-((k-1) mod 16) of device ⌊(k-1)/16⌋ counted from the host. Edge 16·N+1 shows the first device's `sdi`.
- R8: Lowering `cnv` during conversion or during readback returns the device to idle. The next `cnv` rise with `sck` high starts a new conversion from a fresh sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv | input | 1 | Conversion start; held high through conversion and readback |
| sck | input | 1 | Serial clock; its falling edges advance readback |
| sdi | input | 1 | Serial data from the upstream device (tie high on the first device) |
| sample_in | input | W | Value the conversion stub latches at the start edge |
| sdo | output | 1 | Done flag, then result bits, then upstream data |

## Verification
A wrong phase or counter shows at the host's `sdo` on the clock after the slowest device should finish. The done flag rises too early or too late, and the error is counted to the cycle. A corrupted shift register, or a lost first-edge skip, puts a wrong bit on `sdo` at the very falling edge where that bit is read. When one device mishandles `sdi`, the fault surfaces 16 edges later, as the host reads the next device's word.

// File: rtl/chain_adc_port.sv
module chain_adc_port #(
  parameter int W           = 16,
  parameter int CONV_CYCLES = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnv,
  input  logic         sck,
  input  logic         sdi,
  input  logic [W-1:0] sample_in,
  output logic         sdo
);

  localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(CONV_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_READ} st_t;

  st_t           st;
  logic          cnv_q, sck_q, lead;
  logic [CW-1:0] cnt;
  logic [W-1:0]  held, shreg;

  wire cnv_rise = cnv & ~cnv_q;
  wire sck_fall = sck_q & ~sck;
  wire conv_end = (st == S_CONV) && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnv_q <= 1'b0;
      sck_q <= 1'b0;
      lead  <= 1'b0;
      cnt   <= '0;
      held  <= '0;
      shreg <= '0;
    end else begin
      cnv_q <= cnv;
      sck_q <= sck;
      if (!cnv) begin
        st   <= S_IDLE;
        lead <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (cnv_rise && sck) begin
            st   <= S_CONV;
            cnt  <= '0;
            held <= sample_in;
          end
          S_CONV: if (conv_end) begin
            st    <= S_READ;
            shreg <= held;
            lead  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
          S_READ: if (sck_fall) begin
            if (lead) lead  <= 1'b0;
            else      shreg <= {shreg[W-2:0], sdi};
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign sdo = cnv && (st == S_READ) && (lead ? sdi : shreg[W-1]);

  assert_quiet_when_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnv && !cnv_q) |-> (st == S_IDLE));

  assert_start_needs_sck_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cnv && !cnv_q && !sck) |=> (st == S_IDLE));

  assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONV) |-> (cnt <= CNT_LAST));

  assert_conv_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONV && !conv_end && cnv) |=> (st == S_CONV));

  assert_sdo_only_reading_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_READ) |-> !sdo);

  assert_load_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_end && cnv) |=> (st == S_READ && lead && shreg == $past(held)));

  assert_sample_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONV) |=> $stable(held));

endmodule

// File: tb/chain_adc_port_tb.sv
module chain_adc_port_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cnv, sck, sdi_far;
  logic [15:0] va, vb, vc;
  logic        sdo_far, sdo_mid, sdo;
  int          checks = 0, errors = 0;
  bit          done_flag = 1'b0;

  chain_adc_port #(.W(16), .CONV_CYCLES(16)) u_far (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdi_far),
    .sample_in(va), .sdo(sdo_far));
  chain_adc_port #(.W(16), .CONV_CYCLES(20)) u_mid (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdo_far),
    .sample_in(vb), .sdo(sdo_mid));
  chain_adc_port #(.W(16), .CONV_CYCLES(24)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdo_mid),
    .sample_in(vc), .sdo(sdo));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: sdo=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_round(input int r, input bit hold_sdi_low, input int nread);
    va = 16'hA5C3 ^ 16'(r * 16'h1357);
    vb = 16'h8001 + 16'(r * 16'h3C5A);
    vc = 16'h7FFE ^ 16'(r * 16'h0F0F);
    sdi_far = ~hold_sdi_low;
    sck = 1'b1;
    tick();
    cnv = 1'b1;
    tick();
    for (int j = 1; j <= 30; j++) begin
      sck = (j <= 14) ? ~j[0] : 1'b1;
      va = ~va; vb = ~vb; vc = ~vc;
      tick();
      check(sdo, !hold_sdi_low && (j >= 24), j < 24 ? "R3 low during conversion" : "R4 done flag");
    end
    va = 16'hA5C3 ^ 16'(r * 16'h1357);
    vb = 16'h8001 + 16'(r * 16'h3C5A);
    vc = 16'h7FFE ^ 16'(r * 16'h0F0F);
    if (hold_sdi_low) begin
      sdi_far = 1'b1;
      tick();
      check(sdo, 1'b1, "R4 flag follows sdi");
    end
    for (int k = 1; k <= nread; k++) begin
      logic [15:0] w;
      logic        e;
      sck = 1'b0;
      tick();
      if (k <= 48) begin
        w = (k <= 16) ? vc : (k <= 32) ? vb : va;
        e = w[15 - ((k - 1) % 16)];
      end else begin
        e = sdi_far;
      end
      check(sdo, e, k <= 16 ? "R5 own word msb first" : "R7 chained readback");
      sck = 1'b1;
      tick();
    end
  endtask

  initial begin
    rst_n = 1'b0; cnv = 1'b0; sck = 1'b0; sdi_far = 1'b1;
    va = '0; vb = '0; vc = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check(sdo, 1'b0, "R1 reset state");

    cnv = 1'b1;
    tick();
    sck = 1'b1;
    repeat (30) tick();
    check(sdo, 1'b0, "R2 rise with sck low ignored");
    cnv = 1'b0;
    tick();
    check(sdo, 1'b0, "R1 cnv low");

    for (int r = 0; r < 4; r++) begin
      run_round(r, r[0], 49);
      cnv = 1'b0;
      tick();
      check(sdo, 1'b0, "R1 after readback");
      tick();
    end

    va = 16'h1111; vb = 16'h2222; vc = 16'h4444;
    sck = 1'b1;
    tick();
    cnv = 1'b1;
    repeat (10) tick();
    cnv = 1'b0;
    tick();
    check(sdo, 1'b0, "R8 abort in conversion");
    repeat (30) tick();
    check(sdo, 1'b0, "R8 stays idle");
    run_round(5, 1'b0, 20);
    cnv = 1'b0;
    tick();
    check(sdo, 1'b0, "R8 abort in readback");
    run_round(6, 1'b0, 49);
    cnv = 1'b0;
    tick();
    check(sdo, 1'b0, "R1 final idle");

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule